// File: doc/BRIEF.md
# Carrier Bias Allocator for a Cascaded Bridge Rectifier

In a rectifier built from a chain of full-bridge cells, each cell's switching is set by one triangular carrier out of a stack of level-shifted carriers. The middle carrier of the stack puts its cell on the line for the longest time. The two outermost carriers put their cells on the line for the shortest time. This block runs once per sampling period. It decides which carrier each cell uses for that period, so that the cell whose capacitor is furthest from balance gets the strongest correction.

When the period-start strobe is seen, the block captures the cell capacitor voltages, the two modulation references and the sign of the line current. It first classifies the operating point as charging or discharging. It then finds the lowest-voltage cell and the highest-voltage cell with one parallel comparator matrix, with no sort. Finally it hands out carrier slots. The cell that needs the most correction gets the middle slot and the opposite extreme gets the top slot. The other cells take the remaining slots in ascending index order. The result is a slot index per cell, which a PWM generator downstream uses to choose the carrier offset. Slot `s` denotes the carrier whose offset is `s` steps above the lowest one.

Top module: `carrier_bias_alloc`

## Requirements
- R1: `alloc_flag` is 0 (charging) when `ref_a > ref_b` (signed) with `cur_pos`=1, or when `ref_a <= ref_b` with `cur_pos`=0. Otherwise it is 1 (discharging). Equal references count as `ref_a <= ref_b`.
- R2: `lo_cell` is the index of the cell with the smallest captured voltage. Among equal voltages, the lowest index wins.
- R3: `hi_cell` is the index of the cell with the largest voltage among all cells except `lo_cell`. Among equal voltages, the lowest index wins. When all voltages are equal, `lo_cell`=0 and `hi_cell`=1.
- R4: With flag 0, cell `lo_cell` gets slot NCELL/2 (slot 2 for five cells) and cell `hi_cell` gets slot NCELL-1 (slot 4).
- R5: With flag 1, cell `hi_cell` gets slot NCELL/2 and cell `lo_cell` gets slot NCELL-1.
- R6: The other cells, taken in ascending index order, get the slots NCELL/2-1, NCELL/2+1, NCELL/2-2, … in turn. For five cells this is slots 1, 3, 0.
- R7: The slot fields in `bias_sel` (cell i in bits [i*W +: W], W=$clog2(NCELL)) always form a permutation of 0..NCELL-1.
- R8: If `period_start` is high at clock edge k, the new result appears after edge k+1 and `alloc_valid` is high for that one cycle. Each cell's result is based on the inputs present at edge k.
- R9: After reset, `bias_sel` gives cell i slot i, `alloc_flag`=0, `lo_cell`=0, `hi_cell`=1, and `alloc_valid`=0.
- R10: Input changes without `period_start` leave every output unchanged, and `alloc_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_start | input | 1 | Sampling-period strobe; captures all inputs |
| cell_v | input | NCELL*VW | Cell capacitor voltages, cell i in bits [i*VW +: VW], unsigned |
| ref_a | input | RW | First modulation reference, signed |
| ref_b | input | RW | Second modulation reference, signed |
| cur_pos | input | 1 | 1 when the line current is positive |
| bias_sel | output | NCELL*W | Carrier slot index per cell |
| alloc_flag | output | 1 | 0 = charging condition, 1 = discharging condition |
| alloc_valid | output | 1 | One-cycle pulse when a new allocation is presented |
| lo_cell | output | W | Index of the lowest-voltage cell |
| hi_cell | output | W | Index of the highest-voltage cell other than `lo_cell` |

## Verification
Some properties are checked by assertions on every cycle. The comparator matrix must mark exactly one lowest cell and one distinct highest cell, and the lowest cell's voltage must not exceed the highest cell's. The slot vector must stay a permutation. The middle slot must go to the correct extreme for the current flag. The result must follow the strobe after two edges, and the outputs must hold while no capture is pending. Other behaviour can only be shown by the bench's sweep: which cell wins a tie, how the remaining cells fill the leftover slots, the all-equal case, and the flag for equal references. The sweep covers every combination of five 3-bit voltages and rotates through the current and reference cases, comparing against an arithmetic model.

// File: rtl/cba_pkg.sv
package cba_pkg;

  // Slot given to the cell at a priority rank: the centre slot first, then
  // the slots alternate outward below and above the centre.
  function automatic int unsigned slot_of_rank(input int unsigned rank,
                                               input int unsigned ncell);
    int unsigned mid;
    mid = ncell / 2;
    if (rank == 0)
      return mid;
    else if (rank[0])
      return mid - (rank + 1) / 2;
    else
      return mid + rank / 2;
  endfunction

endpackage

// File: rtl/cba_cond.sv
module cba_cond #(
  parameter int RW = 16
) (
  input  logic signed [RW-1:0] ref_a,
  input  logic signed [RW-1:0] ref_b,
  input  logic                 cur_pos,
  output logic                 flag
);
  logic area_one;

  always_comb begin
    area_one = (ref_a > ref_b);
    // charging when the current polarity matches the area, else discharging
    flag = area_one ? ~cur_pos : cur_pos;
  end
endmodule

// File: rtl/cba_extreme.sv
module cba_extreme #(
  parameter int NCELL = 5,
  parameter int VW    = 12,
  parameter int IW    = 3
) (
  input  logic [NCELL*VW-1:0] v,
  output logic [NCELL-1:0]    lo_oh,
  output logic [NCELL-1:0]    hi_oh,
  output logic [IW-1:0]       lo_idx,
  output logic [IW-1:0]       hi_idx
);
  // Full comparator matrix: each cell is judged against every other cell
  // at once; lower index wins a tie by strict/non-strict comparison split.
  always_comb begin : min_matrix
    logic ok;
    for (int i = 0; i < NCELL; i++) begin
      ok = 1'b1;
      for (int j = 0; j < NCELL; j++) begin
        if (j < i)
          ok = ok & (v[i*VW +: VW] <  v[j*VW +: VW]);
        else if (j > i)
          ok = ok & (v[i*VW +: VW] <= v[j*VW +: VW]);
      end
      lo_oh[i] = ok;
    end
  end

  always_comb begin : max_matrix
    logic ok;
    for (int i = 0; i < NCELL; i++) begin
      ok = ~lo_oh[i];
      for (int j = 0; j < NCELL; j++) begin
        if (!lo_oh[j]) begin
          if (j < i)
            ok = ok & (v[i*VW +: VW] >  v[j*VW +: VW]);
          else if (j > i)
            ok = ok & (v[i*VW +: VW] >= v[j*VW +: VW]);
        end
      end
      hi_oh[i] = ok;
    end
  end

  always_comb begin : encode
    lo_idx = '0;
    hi_idx = '0;
    for (int i = 0; i < NCELL; i++) begin
      if (lo_oh[i]) lo_idx = lo_idx | IW'(i);
      if (hi_oh[i]) hi_idx = hi_idx | IW'(i);
    end
  end
endmodule

// File: rtl/cba_slot_map.sv
module cba_slot_map
  import cba_pkg::*;
#(
  parameter int NCELL = 5,
  parameter int IW    = 3
) (
  input  logic [NCELL-1:0]    lo_oh,
  input  logic [NCELL-1:0]    hi_oh,
  input  logic                flag,
  output logic [NCELL*IW-1:0] slot
);
  logic [NCELL-1:0] fav_oh;
  logic [NCELL-1:0] dis_oh;
  logic [NCELL-1:0] rest_oh;

  always_comb begin
    fav_oh  = flag ? hi_oh : lo_oh;
    dis_oh  = flag ? lo_oh : hi_oh;
    rest_oh = ~(lo_oh | hi_oh);
  end

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    always_comb begin : rank_calc
      int unsigned rk;
      if (fav_oh[g]) begin
        rk = 0;
      end else if (dis_oh[g]) begin
        rk = NCELL - 1;
      end else begin
        rk = 1;
        for (int j = 0; j < g; j++)
          if (rest_oh[j]) rk = rk + 1;
      end
      slot[g*IW +: IW] = IW'(slot_of_rank(rk, NCELL));
    end
  end
endmodule

// File: rtl/carrier_bias_alloc.sv
module carrier_bias_alloc #(
  parameter int NCELL = 5,
  parameter int VW    = 12,
  parameter int RW    = 16,
  localparam int IW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                period_start,
  input  logic [NCELL*VW-1:0] cell_v,
  input  logic [RW-1:0]       ref_a,
  input  logic [RW-1:0]       ref_b,
  input  logic                cur_pos,
  output logic [NCELL*IW-1:0] bias_sel,
  output logic                alloc_flag,
  output logic                alloc_valid,
  output logic [IW-1:0]       lo_cell,
  output logic [IW-1:0]       hi_cell
);
  localparam int MID = NCELL / 2;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // ---------------- capture stage ----------------
  logic                cap_vld_q, cap_vld_d;
  logic [NCELL*VW-1:0] cap_v_q,   cap_v_d;
  logic [RW-1:0]       cap_a_q,   cap_a_d;
  logic [RW-1:0]       cap_b_q,   cap_b_d;
  logic                cap_pos_q, cap_pos_d;

  always_comb begin
    cap_vld_d = period_start;
    cap_v_d   = period_start ? cell_v  : cap_v_q;
    cap_a_d   = period_start ? ref_a   : cap_a_q;
    cap_b_d   = period_start ? ref_b   : cap_b_q;
    cap_pos_d = period_start ? cur_pos : cap_pos_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cap_vld_q <= 1'b0;
      cap_v_q   <= '0;
      cap_a_q   <= '0;
      cap_b_q   <= '0;
      cap_pos_q <= 1'b0;
    end else begin
      cap_vld_q <= cap_vld_d;
      cap_v_q   <= cap_v_d;
      cap_a_q   <= cap_a_d;
      cap_b_q   <= cap_b_d;
      cap_pos_q <= cap_pos_d;
    end
  end

  // ---------------- decision logic ----------------
  logic                flag_c;
  logic [NCELL-1:0]    lo_oh, hi_oh;
  logic [IW-1:0]       lo_idx, hi_idx;
  logic [NCELL*IW-1:0] slot_c;

  cba_cond #(.RW(RW)) u_cond (
    .ref_a   (cap_a_q),
    .ref_b   (cap_b_q),
    .cur_pos (cap_pos_q),
    .flag    (flag_c)
  );

  cba_extreme #(.NCELL(NCELL), .VW(VW), .IW(IW)) u_ext (
    .v      (cap_v_q),
    .lo_oh  (lo_oh),
    .hi_oh  (hi_oh),
    .lo_idx (lo_idx),
    .hi_idx (hi_idx)
  );

  cba_slot_map #(.NCELL(NCELL), .IW(IW)) u_map (
    .lo_oh (lo_oh),
    .hi_oh (hi_oh),
    .flag  (flag_c),
    .slot  (slot_c)
  );

  // ---------------- result stage ----------------
  logic [NCELL*IW-1:0] bias_q, bias_d;
  logic                flag_q, flag_d;
  logic [IW-1:0]       lo_q, lo_d, hi_q, hi_d;
  logic                vld_q, vld_d;

  always_comb begin
    vld_d  = cap_vld_q;
    bias_d = cap_vld_q ? slot_c : bias_q;
    flag_d = cap_vld_q ? flag_c : flag_q;
    lo_d   = cap_vld_q ? lo_idx : lo_q;
    hi_d   = cap_vld_q ? hi_idx : hi_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int i = 0; i < NCELL; i++)
        bias_q[i*IW +: IW] <= IW'(i);
      flag_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= IW'(1);
      vld_q  <= 1'b0;
    end else begin
      bias_q <= bias_d;
      flag_q <= flag_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      vld_q  <= vld_d;
    end
  end

  assign bias_sel    = bias_q;
  assign alloc_flag  = flag_q;
  assign alloc_valid = vld_q;
  assign lo_cell     = lo_q;
  assign hi_cell     = hi_q;

  // ---------------- assertions ----------------
  logic [(1<<IW)-1:0] slot_used;
  logic [IW-1:0]      slot_of_lo, slot_of_hi;
  logic [VW-1:0]      v_lo, v_hi;

  always_comb begin
    slot_used  = '0;
    slot_of_lo = '0;
    slot_of_hi = '0;
    v_lo       = '0;
    v_hi       = '0;
    for (int i = 0; i < NCELL; i++) begin
      slot_used[bias_q[i*IW +: IW]] = 1'b1;
      if (IW'(i) == lo_q) slot_of_lo = bias_q[i*IW +: IW];
      if (IW'(i) == hi_q) slot_of_hi = bias_q[i*IW +: IW];
      if (lo_oh[i]) v_lo = cap_v_q[i*VW +: VW];
      if (hi_oh[i]) v_hi = cap_v_q[i*VW +: VW];
    end
  end

  p_lo_onehot_r2: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(lo_oh) == 1);

  p_hi_distinct_r3: assert property (@(posedge clk) disable iff (!rst_q)
    ($countones(hi_oh) == 1) && ((hi_oh & lo_oh) == '0));

  p_lo_not_above_hi_r2: assert property (@(posedge clk) disable iff (!rst_q)
    v_lo <= v_hi);

  p_permutation_r7: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(slot_used) == NCELL);

  p_mid_charge_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (alloc_valid && !alloc_flag) |-> (slot_of_lo == IW'(MID)));

  p_mid_discharge_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (alloc_valid && alloc_flag) |-> (slot_of_hi == IW'(MID)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_q)
    period_start |=> ##1 alloc_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !cap_vld_q |=> ($stable(bias_sel) && $stable(lo_cell) && $stable(hi_cell)
                    && !alloc_valid));

endmodule

// File: tb/sim_carrier_bias_alloc.sv
`timescale 1ns/1ps
module sim_carrier_bias_alloc;
  localparam int N  = 5;
  localparam int VW = 3;
  localparam int RW = 8;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            period_start;
  logic [N*VW-1:0] cell_v;
  logic [RW-1:0]   ref_a, ref_b;
  logic            cur_pos;
  logic [N*IW-1:0] bias_sel;
  logic            alloc_flag, alloc_valid;
  logic [IW-1:0]   lo_cell, hi_cell;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // slot handed to each priority rank, from R4-R6 for five cells
  int ord[N] = '{2, 1, 3, 0, 4};

  int exp_flag, exp_lo, exp_hi;
  int exp_slot[N];

  carrier_bias_alloc #(.NCELL(N), .VW(VW), .RW(RW)) u0 (
    .clk, .rst_n, .period_start, .cell_v, .ref_a, .ref_b, .cur_pos,
    .bias_sel, .alloc_flag, .alloc_valid, .lo_cell, .hi_cell
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int slot_at(input int i);
    return int'(bias_sel[i*IW +: IW]);
  endfunction

  task automatic model(input int v[N], input int ra, input int rb, input bit pos);
    int fav, dis, r;
    exp_flag = (ra > rb) ? int'(!pos) : int'(pos);
    exp_lo = 0;
    for (int i = 1; i < N; i++) if (v[i] < v[exp_lo]) exp_lo = i;
    exp_hi = -1;
    for (int i = 0; i < N; i++)
      if (i != exp_lo && (exp_hi < 0 || v[i] > v[exp_hi])) exp_hi = i;
    fav = exp_flag ? exp_hi : exp_lo;
    dis = exp_flag ? exp_lo : exp_hi;
    r = 1;
    for (int i = 0; i < N; i++) begin
      if (i == fav)      exp_slot[i] = ord[0];
      else if (i == dis) exp_slot[i] = ord[N-1];
      else begin exp_slot[i] = ord[r]; r++; end
    end
  endtask

  task automatic drive(input int v[N], input int ra, input int rb, input bit pos);
    for (int i = 0; i < N; i++) cell_v[i*VW +: VW] = VW'(v[i]);
    ref_a   = RW'(ra);
    ref_b   = RW'(rb);
    cur_pos = pos;
  endtask

  task automatic compare_all();
    logic [N-1:0] used;
    string t;
    chk(alloc_valid == 1'b1, "R8 valid", int'(alloc_valid), 1);
    chk(int'(alloc_flag) == exp_flag, "R1 flag", int'(alloc_flag), exp_flag);
    chk(int'(lo_cell) == exp_lo, "R2 lo_cell", int'(lo_cell), exp_lo);
    chk(int'(hi_cell) == exp_hi, "R3 hi_cell", int'(hi_cell), exp_hi);
    used = '0;
    for (int i = 0; i < N; i++) begin
      if (i == exp_lo || i == exp_hi) t = exp_flag ? "R5 slot" : "R4 slot";
      else t = "R6 slot";
      chk(slot_at(i) == exp_slot[i], t, slot_at(i), exp_slot[i]);
      if (slot_at(i) < N) used[slot_at(i)] = 1'b1;
    end
    chk(used == '1, "R7 permutation", int'(used), (1 << N) - 1);
  endtask

  initial begin
    int v[N];
    int ra, rb, cond;
    bit pos;
    logic [N*IW-1:0] held;
    rst_n = 1'b0; period_start = 1'b0; cell_v = '0; ref_a = '0; ref_b = '0; cur_pos = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    for (int i = 0; i < N; i++) chk(slot_at(i) == i, "R9 reset slot", slot_at(i), i);
    chk(alloc_valid == 1'b0, "R9 reset valid", int'(alloc_valid), 0);
    chk(alloc_flag == 1'b0, "R9 reset flag", int'(alloc_flag), 0);
    chk(lo_cell == 0 && hi_cell == 1, "R9 reset lo/hi", int'(hi_cell), 1);

    // R8 latency and single-cycle pulse; all-equal voltages exercise R3
    v = '{3, 3, 3, 3, 3};
    drive(v, 10, 10, 1'b0);
    model(v, 10, 10, 1'b0);
    period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    chk(alloc_valid == 1'b0, "R8 not yet valid", int'(alloc_valid), 0);
    @(negedge clk);
    compare_all();
    chk(lo_cell == 0 && hi_cell == 1, "R3 all equal", int'(hi_cell), 1);
    @(negedge clk);
    chk(alloc_valid == 1'b0, "R8 pulse ends", int'(alloc_valid), 0);

    // R10: inputs change without a strobe
    held = bias_sel;
    v = '{7, 0, 5, 1, 6};
    drive(v, -20, 30, 1'b1);
    repeat (4) @(negedge clk);
    chk(bias_sel == held, "R10 slots held", int'(bias_sel), int'(held));
    chk(lo_cell == 0 && hi_cell == 1, "R10 lo/hi held", int'(lo_cell), 0);
    chk(alloc_valid == 1'b0, "R10 no valid", int'(alloc_valid), 0);

    // exhaustive sweep of five 3-bit voltages, rotating the condition
    for (int k = 0; k < (1 << (N*VW)); k++) begin
      for (int i = 0; i < N; i++) v[i] = (k >> (VW*i)) & 7;
      cond = (k + k / 7) & 3;
      pos  = cond[0];
      if (k % 11 == 0)   begin ra = 7;   rb = 7;   end
      else if (cond[1])  begin ra = 20;  rb = -5;  end
      else               begin ra = -5;  rb = 20;  end
      drive(v, ra, rb, pos);
      model(v, ra, rb, pos);
      period_start = 1'b1;
      @(negedge clk); period_start = 1'b0;
      @(negedge clk);
      compare_all();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule